// File: doc/BRIEF.md
# Multimode Serial Port with Framing Check

This block is a full-duplex serial port. It has four operating modes. Mode 0 is a synchronous shifter: it drives the shift clock on the TX pin and moves eight data bits, LSB first, over the bidirectional data pin. Modes 1, 2 and 3 are asynchronous:

- Mode 1 uses a 10-bit frame.
- Modes 2 and 3 use an 11-bit frame, whose ninth data bit comes from a control bit.
- Modes 1 and 3 take their rate from an externally supplied timer oversample enable.
- Mode 2 takes its rate from a fixed oversample enable.
- A doubler input selects whether one or two enable pulses make one oversample step.

Software sees a single 8-bit control register. It also sees a transmit write port and the received-byte output. The receiver can filter frames for multiprocessor addressing and can discard frames whose stop bit is invalid. The top bit of the control register holds one of two values, chosen by a select input. With the select low it is the high mode bit. With the select high it is a sticky framing-error flag. The two values are stored separately.

Top module: `sp_port`

## Requirements
- R1: After reset the control register reads 0x00, the TX pin is high and the data pin is not driven. Register bits, MSB first: [7] mode-high or error flag, [6] mode-low, [5] multiprocessor enable, [4] receive enable, [3] transmit 9th bit, [2] received 9th bit, [1] transmit-done, [0] receive-done. Bits 6..0 read back what was written.
- R2: Mode 0 transmit starts on a transmit write. Each bit lasts 2*M0_HALF clocks. The shift clock on the TX pin is low for the first half of the bit and high for the second half. Data on the data pin is stable across the rising edge and goes out LSB first. Transmit-done sets at the end of the 8th bit.
- R3: In mode 0, receive enable set with receive-done clear starts a reception. The pin is sampled at the end of each high phase, LSB first. Receive-done sets after 8 bits, and no new reception starts while it remains set.
- R4: An asynchronous transmit sends a low start bit, 8 data bits LSB first, then (modes 2 and 3 only) the transmit 9th bit, then a high stop bit. Each bit lasts 16 oversample steps. Transmit-done sets at the end of the stop bit.
- R5: The asynchronous receiver takes a 2-of-3 majority vote at steps 7, 8 and 9 of each bit. A one-clock glitch therefore does not corrupt data. An accepted frame loads the byte and sets receive-done. The received 9th bit is loaded too: the 9th bit in modes 2 and 3, or the stop bit in mode 1.
- R6: A start bit that votes high at mid-bit is rejected, and the receiver returns to idle.
- R7: In modes 2 and 3 with multiprocessor enable set, a frame whose 9th bit is 0 leaves receive-done and the buffer unchanged.
- R8: In mode 1 with multiprocessor enable set, a frame with a low stop bit is discarded.
- R9: With the select high, bit 7 reads and writes the error flag. The flag sets on any low stop bit, stays set until software writes 0, and writing it leaves the mode bit unchanged.
- R10: With the doubler low, an oversample step takes two enable pulses, so an async bit takes twice as long as with the doubler high.
- R11: Mode 2 steps on the fixed enable, and modes 1 and 3 step on the timer enable.
- R12: Transmit-done and receive-done stay set until software writes the register.
- R13: With receive enable clear, asynchronous frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| tx_we | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last accepted received byte |
| fe_sel | input | 1 | Selects error flag (1) or mode bit (0) at bit 7 |
| dbl | input | 1 | Baud doubler |
| fix_tick | input | 1 | Fixed-rate oversample enable |
| tmr_tick | input | 1 | Timer-derived oversample enable |
| rxd_in | input | 1 | Data pin input |
| rxd_out | output | 1 | Data pin output value in mode 0 |
| rxd_oe | output | 1 | Data pin output enable |
| txd | output | 1 | TX pin: async data or mode 0 shift clock |

## Verification
The bench builds the port with M0_HALF = 3 and OSR = 16. A mode 0 bit therefore lasts six clocks, which leaves one clock of margin after the two-flop input synchronizer. An async bit is 16 or 32 clocks, so every mode, both doubler settings and both rate sources fit into a short run. These values also let a one-clock glitch land on exactly one vote sample. They let the bench place a false start and the re-arm after a bad stop bit at clock-exact positions.

// File: rtl/sp_pkg.sv
package sp_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [1:0] {
        MD_SHIFT = 2'd0,
        MD_A10   = 2'd1,
        MD_A11F  = 2'd2,
        MD_A11T  = 2'd3
    } sp_mode_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/sp_rate.sv
module sp_rate (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic dbl,
    output logic samp
);
    timeunit 1ns;
    timeprecision 100ps;

    logic half_d, half_q;

    always_comb begin
        half_d = half_q;
        if (tick) half_d = ~half_q;
        samp = tick & (dbl | half_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= half_d;
    end

    // R10
    half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl && samp) |=> (dbl || !samp));
endmodule

// File: rtl/sp_atx.sv
module sp_atx #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       samp,
    input  logic       load,
    input  logic [7:0] data,
    input  logic       nine,
    input  logic       b9,
    output logic       txd,
    output logic       done
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int SW = $clog2(OSR);

    typedef struct packed {
        logic          busy;
        logic [10:0]   sh;
        logic [3:0]    left;
        logic [SW-1:0] sub;
    } st_t;

    st_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (load) begin
            d.busy = 1'b1;
            d.sh   = {1'b1, (nine ? b9 : 1'b1), data, 1'b0};
            d.left = nine ? 4'd11 : 4'd10;
            d.sub  = '0;
        end else if (q.busy && samp) begin
            if (q.sub == SW'(OSR - 1)) begin
                d.sub = '0;
                if (q.left == 4'd1) begin
                    d.busy = 1'b0;
                    done   = 1'b1;
                end else begin
                    d.sh   = {1'b1, q.sh[10:1]};
                    d.left = q.left - 4'd1;
                end
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end
        txd = q.busy ? q.sh[0] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd);
    // R4
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> txd);
endmodule

// File: rtl/sp_arx.sv
module sp_arx #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       samp,
    input  logic       rxd,
    input  logic       en,
    input  logic       nine,
    output logic       fdone,
    output logic [7:0] fdata,
    output logic       fb9,
    output logic       fstop
);
    timeunit 1ns;
    timeprecision 100ps;
    import sp_pkg::*;

    localparam int SW  = $clog2(OSR);
    localparam int MID = OSR / 2;

    typedef struct packed {
        logic          act;
        logic [SW-1:0] sub;
        logic [3:0]    idx;
        logic [1:0]    v;
        logic [7:0]    sh;
        logic          b9;
    } st_t;

    st_t q, d;
    logic       vote;
    logic [3:0] last;

    always_comb begin
        d     = q;
        fdone = 1'b0;
        last  = nine ? 4'd10 : 4'd9;
        vote  = maj3(q.v[0], q.v[1], rxd);
        if (!q.act) begin
            if (en && samp && !rxd) begin
                d.act = 1'b1;
                d.sub = '0;
                d.idx = '0;
            end
        end else if (samp) begin
            d.sub = (q.sub == SW'(OSR - 1)) ? '0 : q.sub + 1'b1;
            if (q.sub == SW'(MID - 1)) d.v[0] = rxd;
            if (q.sub == SW'(MID))     d.v[1] = rxd;
            if (q.sub == SW'(MID + 1)) begin
                if (q.idx == 4'd0) begin
                    if (vote) d.act = 1'b0;
                end else if (q.idx == last) begin
                    d.act = 1'b0;
                    fdone = 1'b1;
                end else if (q.idx <= 4'd8) begin
                    d.sh = {vote, q.sh[7:1]};
                end else begin
                    d.b9 = vote;
                end
            end
            if (q.sub == SW'(OSR - 1)) d.idx = q.idx + 4'd1;
        end
        fdata = q.sh;
        fb9   = nine ? q.b9 : vote;
        fstop = vote;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act && samp && q.idx == 4'd0 && q.sub == SW'(MID + 1) && q.v == 2'b11 && rxd)
        |=> !q.act);
endmodule

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_tx,
    input  logic       go_rx,
    input  logic [7:0] data,
    input  logic       rxd,
    output logic       sclk,
    output logic       dout,
    output logic       doe,
    output logic       done_tx,
    output logic       done_rx,
    output logic [7:0] rdata
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int PW   = $clog2(2 * HALF);
    localparam int LAST = 2 * HALF - 1;

    typedef struct packed {
        logic          act;
        logic          dir;
        logic [PW-1:0] ph;
        logic [2:0]    cnt;
        logic [7:0]    sh;
    } st_t;

    st_t q, d;

    always_comb begin
        d       = q;
        done_tx = 1'b0;
        done_rx = 1'b0;
        rdata   = {rxd, q.sh[7:1]};
        if (!q.act) begin
            if (go_tx || go_rx) begin
                d.act = 1'b1;
                d.dir = go_tx;
                d.sh  = go_tx ? data : 8'h00;
                d.ph  = '0;
                d.cnt = '0;
            end
        end else if (q.ph == PW'(LAST)) begin
            d.ph  = '0;
            d.sh  = q.dir ? {1'b1, q.sh[7:1]} : {rxd, q.sh[7:1]};
            d.cnt = q.cnt + 3'd1;
            if (q.cnt == 3'd7) begin
                d.act   = 1'b0;
                done_tx = q.dir;
                done_rx = !q.dir;
            end
        end else begin
            d.ph = q.ph + 1'b1;
        end
        sclk = q.act ? (q.ph >= PW'(HALF)) : 1'b1;
        dout = (q.act && q.dir) ? q.sh[0] : 1'b1;
        doe  = q.act && q.dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2
    sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_tx && !q.act) |=> (!sclk && doe));
    // R3
    rx_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_rx && !go_tx && !q.act) |=> !doe);
endmodule

// File: rtl/sp_port.sv
module sp_port #(
    parameter int M0_HALF = 4,
    parameter int OSR     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       tx_we,
    input  logic [7:0] tx_wdata,
    output logic [7:0] rx_data,
    input  logic       fe_sel,
    input  logic       dbl,
    input  logic       fix_tick,
    input  logic       tmr_tick,
    input  logic       rxd_in,
    output logic       rxd_out,
    output logic       rxd_oe,
    output logic       txd
);
    timeunit 1ns;
    timeprecision 100ps;
    import sp_pkg::*;

    typedef struct packed {
        logic       mode_hi;
        logic       mode_lo;
        logic       mp_en;
        logic       rx_en;
        logic       tx_b9;
        logic       rx_b9;
        logic       tx_done;
        logic       rx_done;
        logic       fe;
        logic [7:0] rbuf;
        logic [1:0] sy;
    } rg_t;

    rg_t q, d;
    sp_mode_e md;
    logic rxs, is_async, nine, tick, samp, accept;
    logic a_txd, a_done;
    logic fdone, fb9, fstop;
    logic [7:0] fdata, s_rdata;
    logic s_clk, s_done_tx, s_done_rx;

    assign md       = sp_mode_e'({q.mode_hi, q.mode_lo});
    assign is_async = (md != MD_SHIFT);
    assign nine     = md[1];
    assign rxs      = q.sy[1];
    assign tick     = (md == MD_A11F) ? fix_tick : tmr_tick;

    sp_rate u_rate (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dbl(dbl), .samp(samp)
    );

    sp_atx #(.OSR(OSR)) u_atx (
        .clk(clk), .rst_n(rst_n), .samp(samp), .load(tx_we && is_async),
        .data(tx_wdata), .nine(nine), .b9(q.tx_b9), .txd(a_txd), .done(a_done)
    );

    sp_arx #(.OSR(OSR)) u_arx (
        .clk(clk), .rst_n(rst_n), .samp(samp), .rxd(rxs),
        .en(is_async && q.rx_en), .nine(nine), .fdone(fdone),
        .fdata(fdata), .fb9(fb9), .fstop(fstop)
    );

    sp_sync #(.HALF(M0_HALF)) u_sync (
        .clk(clk), .rst_n(rst_n), .go_tx(tx_we && !is_async),
        .go_rx(!is_async && q.rx_en && !q.rx_done), .data(tx_wdata), .rxd(rxs),
        .sclk(s_clk), .dout(rxd_out), .doe(rxd_oe),
        .done_tx(s_done_tx), .done_rx(s_done_rx), .rdata(s_rdata)
    );

    always_comb begin
        d      = q;
        d.sy   = {q.sy[0], rxd_in};
        accept = nine ? (!q.mp_en || fb9) : (!q.mp_en || fstop);
        if (reg_we) begin
            if (fe_sel) d.fe      = reg_wdata[7];
            else        d.mode_hi = reg_wdata[7];
            d.mode_lo = reg_wdata[6];
            d.mp_en   = reg_wdata[5];
            d.rx_en   = reg_wdata[4];
            d.tx_b9   = reg_wdata[3];
            d.rx_b9   = reg_wdata[2];
            d.tx_done = reg_wdata[1];
            d.rx_done = reg_wdata[0];
        end
        if (a_done || s_done_tx) d.tx_done = 1'b1;
        if (s_done_rx) begin
            d.rbuf    = s_rdata;
            d.rx_done = 1'b1;
        end
        if (fdone && is_async) begin
            if (!fstop) d.fe = 1'b1;
            if (accept) begin
                d.rbuf    = fdata;
                d.rx_b9   = fb9;
                d.rx_done = 1'b1;
            end
        end
        reg_rdata = {(fe_sel ? q.fe : q.mode_hi), q.mode_lo, q.mp_en, q.rx_en,
                     q.tx_b9, q.rx_b9, q.tx_done, q.rx_done};
        rx_data   = q.rbuf;
        txd       = is_async ? a_txd : s_clk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.sy <= 2'b11;
        end else begin
            q <= d;
        end
    end

    // R9
    fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fe && !(reg_we && fe_sel)) |=> q.fe);
    // R9
    mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && fe_sel) |=> $stable(q.mode_hi));
    // R7
    mp_nine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fdone && nine && q.mp_en && !fb9 && !q.rx_done && !reg_we) |=> !q.rx_done);
    // R8
    mp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fdone && md == MD_A10 && q.mp_en && !fstop && !q.rx_done && !reg_we) |=> !q.rx_done);
    // R12
    rx_done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rx_done && !reg_we) |=> q.rx_done);
endmodule

// File: tb/sp_port_tb.sv
module sp_port_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int HALF = 3;
    localparam int OSR  = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 0, tx_we = 0, fe_sel = 0, dbl = 1, fix_tick = 0, tmr_tick = 1, rxd_in = 1;
    logic [7:0] reg_wdata = 0, tx_wdata = 0, reg_rdata, rx_data;
    logic rxd_out, rxd_oe, txd;

    int checks = 0, errors = 0, sent = 0, seen = 0;
    int bitlen = OSR, nbits = 10;
    bit mon_on = 0;
    string mon_tag = "R4";
    logic [10:0] exp_q[$];

    always #2.5 clk = ~clk;

    sp_port #(.M0_HALF(HALF), .OSR(OSR)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_data(rx_data),
        .fe_sel(fe_sel), .dbl(dbl), .fix_tick(fix_tick), .tmr_tick(tmr_tick),
        .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd(txd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); reg_we = 1; reg_wdata = v;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic wr_tx(input logic [7:0] v);
        @(negedge clk); tx_we = 1; tx_wdata = v;
        @(negedge clk); tx_we = 0;
    endtask

    task automatic push_tx(input logic [10:0] frame, input int nb, input int bl, input logic [7:0] ctl);
        nbits = nb; bitlen = bl;
        exp_q.push_back(frame); sent++;
        wr_tx(frame[8:1]);
        repeat ((nb + 1) * bl) @(negedge clk);
        chk({mon_tag, " tx_done after frame"}, reg_rdata[1], 1'b1);
        wr_ctrl(ctl);
    endtask

    task automatic send(input logic [10:0] bits, input int nb, input int bl, input int gbit);
        for (int i = 0; i < nb; i++) begin
            for (int c = 0; c < bl; c++) begin
                rxd_in = (i == gbit && c == bl / 2) ? ~bits[i] : bits[i];
                @(negedge clk);
            end
        end
        rxd_in = 1'b1;
        repeat (2 * bl) @(negedge clk);
    endtask

    // fixed-rate enable: every other clock
    initial forever begin
        @(negedge clk); fix_tick = ~fix_tick;
    end

    // scoreboard monitor for asynchronous transmit frames
    initial forever begin
        @(negedge clk);
        if (mon_on && txd === 1'b0) begin : dec
            logic [10:0] got;
            logic [10:0] exp;
            got = '0;
            repeat (bitlen / 2) @(negedge clk);
            got[0] = txd;
            for (int i = 1; i < nbits; i++) begin
                repeat (bitlen) @(negedge clk);
                got[i] = txd;
            end
            seen++;
            if (exp_q.size() == 0) chk({mon_tag, " unexpected frame"}, got, 11'h7ff);
            else begin
                exp = exp_q.pop_front();
                chk({mon_tag, " frame bits"}, got, exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got;
        int lows;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl reset", reg_rdata, 8'h00);
        chk("R1 txd idle", txd, 1'b1);
        chk("R1 pin undriven", rxd_oe, 1'b0);
        wr_ctrl(8'h2C);
        chk("R1 readback", reg_rdata, 8'h2C);
        wr_ctrl(8'h00);

        // R2 mode 0 transmit
        wr_tx(8'hA5);
        chk("R2 clock low at start", txd, 1'b0);
        chk("R2 pin driven", rxd_oe, 1'b1);
        got = '0;
        for (int i = 0; i < 8; i++) begin
            @(posedge txd); #1;
            got[i] = rxd_out;
            if (i == 7) chk("R2 tx_done not before end", reg_rdata[1], 1'b0);
        end
        chk("R2 shifted byte", got, 8'hA5);
        repeat (2 * HALF) @(negedge clk);
        chk("R2 tx_done", reg_rdata[1], 1'b1);
        repeat (10) @(negedge clk);
        chk("R12 tx_done held", reg_rdata[1], 1'b1);
        wr_ctrl(8'h00);
        chk("R12 tx_done cleared", reg_rdata[1], 1'b0);

        // R3 mode 0 receive of 0x3C
        rxd_in = 1'b0;
        wr_ctrl(8'h10);
        @(negedge txd);
        for (int k = 1; k < 8; k++) begin
            @(negedge txd);
            rxd_in = k[0] ? 1'b0 : 1'b1;
            if (k == 1 || k == 6 || k == 7) rxd_in = 1'b0;
            if (k == 2 || k == 3 || k == 4 || k == 5) rxd_in = 1'b1;
        end
        repeat (2 * HALF + 2) @(negedge clk);
        chk("R3 rx_done", reg_rdata[0], 1'b1);
        chk("R3 byte", rx_data, 8'h3C);
        lows = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R3 no restart while done", lows, 0);
        wr_ctrl(8'h00);
        rxd_in = 1'b1;

        // R4 async transmit, mode 1
        mon_on = 1;
        wr_ctrl(8'h40);
        nbits = 10; bitlen = OSR; mon_tag = "R4";
        exp_q.push_back({1'b0, 1'b1, 8'h5A, 1'b0}); sent++;
        wr_tx(8'h5A);
        repeat (149) @(negedge clk);
        chk("R4 tx_done not during stop", reg_rdata[1], 1'b0);
        repeat (12) @(negedge clk);
        chk("R4 tx_done at end of stop", reg_rdata[1], 1'b1);
        wr_ctrl(8'h40);
        // R4 mode 3, ninth bit from control
        wr_ctrl(8'hC8);
        push_tx({1'b1, 1'b1, 8'hC3, 1'b0}, 11, OSR, 8'hC0);
        push_tx({1'b1, 1'b0, 8'h81, 1'b0}, 11, OSR, 8'hC0);
        // R11 mode 2 uses the fixed enable (half rate here)
        mon_tag = "R11";
        wr_ctrl(8'h88);
        push_tx({1'b1, 1'b1, 8'h7E, 1'b0}, 11, 2 * OSR, 8'h80);
        // R10 doubler off halves the rate
        mon_tag = "R10";
        dbl = 0;
        wr_ctrl(8'h40);
        push_tx({1'b0, 1'b1, 8'hE1, 1'b0}, 10, 2 * OSR, 8'h40);
        dbl = 1;
        repeat (OSR) @(negedge clk);
        chk("R4 scoreboard frames seen", seen, sent);

        // R5 async receive, mode 1: rx_b9 takes the stop bit
        wr_ctrl(8'h50);
        send({2'b01, 8'h96, 1'b0}, 10, OSR, -1);
        chk("R5 mode1 rx_done", reg_rdata[0], 1'b1);
        chk("R5 mode1 byte", rx_data, 8'h96);
        chk("R5 mode1 stop in rx_b9", reg_rdata[2], 1'b1);
        // R5 mode 3 with a one-clock glitch in data bit 2
        wr_ctrl(8'hD0);
        send({1'b1, 1'b0, 8'h3E, 1'b0}, 11, OSR, 3);
        chk("R5 majority byte", rx_data, 8'h3E);
        chk("R5 ninth bit", reg_rdata[2], 1'b0);
        chk("R5 mode3 rx_done", reg_rdata[0], 1'b1);

        // R6 false start
        wr_ctrl(8'hD0);
        rxd_in = 1'b0;
        repeat (3) @(negedge clk);
        rxd_in = 1'b1;
        repeat (3 * OSR) @(negedge clk);
        chk("R6 false start ignored", reg_rdata[0], 1'b0);
        send({1'b1, 1'b1, 8'h11, 1'b0}, 11, OSR, -1);
        chk("R6 recovery byte", rx_data, 8'h11);

        // R7 multiprocessor filter on ninth bit
        wr_ctrl(8'hF0);
        send({1'b1, 1'b0, 8'h44, 1'b0}, 11, OSR, -1);
        chk("R7 data frame rejected", reg_rdata[0], 1'b0);
        chk("R7 buffer kept", rx_data, 8'h11);
        send({1'b1, 1'b1, 8'h55, 1'b0}, 11, OSR, -1);
        chk("R7 address frame accepted", rx_data, 8'h55);
        chk("R7 rx_done", reg_rdata[0], 1'b1);

        // R8 mode 1 multiprocessor: bad stop discarded
        wr_ctrl(8'h70);
        send({2'b00, 8'h66, 1'b0}, 10, OSR, -1);
        chk("R8 bad stop rejected", reg_rdata[0], 1'b0);
        chk("R8 buffer kept", rx_data, 8'h55);
        send({2'b01, 8'h77, 1'b0}, 10, OSR, -1);
        chk("R8 good stop accepted", rx_data, 8'h77);

        // R9 framing-error flag
        fe_sel = 1;
        wr_ctrl(8'h50);
        chk("R9 flag clear", reg_rdata[7], 1'b0);
        send({2'b00, 8'h12, 1'b0}, 10, OSR, -1);
        chk("R9 flag set", reg_rdata[7], 1'b1);
        chk("R9 frame loaded", rx_data, 8'h12);
        wr_ctrl(8'hD0);
        send({2'b01, 8'h34, 1'b0}, 10, OSR, -1);
        chk("R9 flag sticky", reg_rdata[7], 1'b1);
        fe_sel = 0;
        @(negedge clk);
        chk("R9 mode bit untouched", reg_rdata[7], 1'b0);
        fe_sel = 1;
        wr_ctrl(8'h50);
        chk("R9 software clear", reg_rdata[7], 1'b0);
        fe_sel = 0;

        // R13 receive disabled
        wr_ctrl(8'h40);
        send({2'b01, 8'h99, 1'b0}, 10, OSR, -1);
        chk("R13 no rx_done", reg_rdata[0], 1'b0);
        chk("R13 buffer kept", rx_data, 8'h34);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule